// File: doc/BRIEF.md
# Per-Peripheral Generated Clock Unit

This block produces one divided clock per peripheral slot from a shared pool of six source clocks. Each slot keeps its own source choice, an 8-bit divide field and an enable. Software reaches all slots through a single indirect control word. A write with the command flag clear only points the selector at a slot, and the read port then shows that slot's settings. A write with the command flag set stores new settings into the slot named in the same word. A single ready flag drops when new settings are committed. It rises again once the reprogrammed slot has produced one complete output period on its new source.

The source clocks arrive as plain levels and are sampled in the system clock domain. Their rising edges act as count strobes, so every generated output is a registered level in the system domain. Control word layout: bit 31 is the command flag, bit 28 the enable, bits 27:20 the divide field, bits 18:16 the source select, and bits 3:0 the slot number. Every other bit reads as zero.

Each slot runs a three-state machine. CH_OFF holds the output low. CH_PRIME waits for the first source rising edge after a commit. CH_RUN counts source periods. The transitions are: any commit moves to CH_PRIME; CH_PRIME moves to CH_RUN on a source rising edge; CH_PRIME or CH_RUN moves to CH_OFF when the slot is disabled or its source is reserved; CH_OFF moves to CH_PRIME when the slot becomes live. The ready tracker has three states. RDY_IDLE drives ready high. Any commit moves it to RDY_SETTLE. RDY_SETTLE moves to RDY_IDLE if the target slot is not live or has already finished a period, and to RDY_WAIT otherwise. RDY_WAIT moves to RDY_IDLE on the target's period-complete strobe, or when the target stops being live.

Top module: `gck_gen`

## Requirements
- R1: A control write with bit 31 clear changes no slot settings. It only selects the slot in bits 3:0. The read word then shows that slot's enable (bit 28), divide field (27:20), source select (18:16) and slot number (3:0), and all other bits are zero.
- R2: A control write with bit 31 set and a slot number of 0 to 7 stores that word's enable, divide field and source select into that slot and selects it.
- R3: Slot numbers 8 to 15 are unsupported. Selecting one makes the read word all zeros. A command write to one leaves every slot's settings and the ready flag unchanged.
- R4: A live slot with divide field D and source period P (in system cycles) produces an output period of (D+1)*P.
- R5: For a ratio N=D+1 above one, the output is high for floor(N/2) source periods. With ratio one, the output follows the selected source level.
- R6: Source select values 0 to 5 pick src_clk[value]. Values 6 and 7 hold the output low.
- R7: A slot whose enable is clear drives its output low.
- R8: The ready flag is low in the cycle after a committing write.
- R9: After committing a live setting, ready returns high no sooner than N*P cycles and no later than (N+1)*P+4 cycles after the write. For a disabled slot or a reserved source, it returns within 2 cycles.
- R10: After reset, every slot is disabled with zero fields, all outputs are low, ready is high, and slot 0 is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word written |
| ctrl_rdata | output | 32 | Settings of the currently selected slot |
| gck_ready | output | 1 | High when the last committed setting has taken effect |
| src_clk | input | 6 | Source clock levels |
| gck_out | output | 8 | Generated clock per slot |

## Verification
A wrong period counter shows up in the first output period after ready rises: the high time or the period comes out a whole source period off. A slot state machine stuck in CH_PRIME or CH_RUN leaves a disabled or reserved-source output toggling, which shows within one source period. A broken ready tracker either keeps ready high in the cycle right after a commit, or lets it rise before N*P cycles have passed. A decode error on the slot number corrupts the readback at once, on the next read of the affected slot.

// File: rtl/gck_pkg.sv
package gck_pkg;
    localparam int DATA_W   = 32;
    localparam int PID_W    = 4;
    localparam int SRC_W    = 3;
    localparam int DIV_W    = 8;
    localparam int CMD_BIT  = 31;
    localparam int EN_BIT   = 28;
    localparam int DIV_LSB  = 20;
    localparam int SRC_LSB  = 16;
    localparam int PID_LSB  = 0;

    typedef struct packed {
        logic             en;
        logic [DIV_W-1:0] div;
        logic [SRC_W-1:0] src;
    } gck_cfg_t;

    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_PRIME = 2'd1,
        CH_RUN   = 2'd2
    } ch_state_t;

    typedef enum logic [1:0] {
        RDY_IDLE   = 2'd0,
        RDY_SETTLE = 2'd1,
        RDY_WAIT   = 2'd2
    } rdy_state_t;
endpackage

// File: rtl/gck_src_edge.sv
module gck_src_edge #(
    parameter int NUM_SRC = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_clk,
    output logic [NUM_SRC-1:0] src_lvl,
    output logic [NUM_SRC-1:0] src_rise
);
    logic [NUM_SRC-1:0] lvl_q;
    logic [NUM_SRC-1:0] lvl_d1_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q    <= '0;
            lvl_d1_q <= '0;
        end else begin
            lvl_q    <= src_clk;
            lvl_d1_q <= lvl_q;
        end
    end

    assign src_lvl  = lvl_q;
    assign src_rise = lvl_q & ~lvl_d1_q;
endmodule

// File: rtl/gck_cfg_regs.sv
module gck_cfg_regs
    import gck_pkg::*;
#(
    parameter int NUM_PERIPH = 8,
    localparam int IDX_W = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             ctrl_wr,
    input  logic [DATA_W-1:0]                ctrl_wdata,
    output logic [DATA_W-1:0]                ctrl_rdata,
    output gck_cfg_t [NUM_PERIPH-1:0]        cfg_o,
    output logic                             commit_o,
    output logic [IDX_W-1:0]                 commit_idx_o
);
    localparam logic [PID_W:0] PID_LIMIT = (PID_W+1)'(NUM_PERIPH);
    localparam logic [DATA_W-1:0] USED_MASK =
        (DATA_W'(1) << CMD_BIT) | (DATA_W'(1) << EN_BIT) |
        (DATA_W'((1 << DIV_W) - 1) << DIV_LSB) |
        (DATA_W'((1 << SRC_W) - 1) << SRC_LSB) |
        (DATA_W'((1 << PID_W) - 1) << PID_LSB);

    logic [PID_W-1:0]           sel_q;
    gck_cfg_t [NUM_PERIPH-1:0]  cfg_q;
    logic [PID_W-1:0]           wr_pid;
    logic                       wr_cmd;
    logic                       wr_ok;
    logic                       sel_ok;
    gck_cfg_t                   wr_cfg;
    gck_cfg_t                   rd_cfg;
    logic                       unused_bits;

    assign wr_pid     = ctrl_wdata[PID_LSB +: PID_W];
    assign wr_cmd     = ctrl_wdata[CMD_BIT];
    assign wr_ok      = {1'b0, wr_pid} < PID_LIMIT;
    assign wr_cfg.en  = ctrl_wdata[EN_BIT];
    assign wr_cfg.div = ctrl_wdata[DIV_LSB +: DIV_W];
    assign wr_cfg.src = ctrl_wdata[SRC_LSB +: SRC_W];
    assign unused_bits = ^(ctrl_wdata & ~USED_MASK);

    assign commit_o     = ctrl_wr && wr_cmd && wr_ok;
    assign commit_idx_o = wr_pid[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            cfg_q <= '0;
        end else if (ctrl_wr) begin
            sel_q <= wr_pid;
            if (commit_o) begin
                cfg_q[commit_idx_o] <= wr_cfg;
            end
        end
    end

    assign sel_ok = {1'b0, sel_q} < PID_LIMIT;
    assign rd_cfg = cfg_q[sel_q[IDX_W-1:0]];

    always_comb begin
        ctrl_rdata = '0;
        if (sel_ok) begin
            ctrl_rdata[EN_BIT]                = rd_cfg.en;
            ctrl_rdata[DIV_LSB +: DIV_W]      = rd_cfg.div;
            ctrl_rdata[SRC_LSB +: SRC_W]      = rd_cfg.src;
            ctrl_rdata[PID_LSB +: PID_W]      = sel_q;
        end
    end

    assign cfg_o = cfg_q;

    AST_SELECT_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !ctrl_wdata[CMD_BIT]) |=> $stable(cfg_q)); // R1
    AST_UNSUPPORTED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_wdata[CMD_BIT] && !wr_ok) |=> $stable(cfg_q)); // R3
endmodule

// File: rtl/gck_channel.sv
module gck_channel
    import gck_pkg::*;
#(
    parameter int NUM_SRC = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  gck_cfg_t           cfg,
    input  logic               restart,
    input  logic [NUM_SRC-1:0] src_lvl,
    input  logic [NUM_SRC-1:0] src_rise,
    output logic               gck,
    output logic               live,
    output logic               period_done
);
    ch_state_t        state_q;
    ch_state_t        state_d;
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] cnt_n;
    logic             gck_q;
    logic             src_ok;
    logic             sel_lvl;
    logic             sel_rise;
    logic [DIV_W:0]   ratio;
    logic [DIV_W-1:0] hi_len;

    assign src_ok = 32'(cfg.src) < NUM_SRC;
    assign live   = cfg.en && src_ok;

    always_comb begin
        sel_lvl  = 1'b0;
        sel_rise = 1'b0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (32'(cfg.src) == s) begin
                sel_lvl  = src_lvl[s];
                sel_rise = src_rise[s];
            end
        end
    end

    assign ratio  = (DIV_W+1)'(cfg.div) + (DIV_W+1)'(1);
    assign hi_len = ratio[DIV_W:1];
    assign cnt_n  = (cnt_q == cfg.div) ? '0 : cnt_q + DIV_W'(1);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (restart) begin
            state_d = CH_PRIME;
        end else begin
            unique case (state_q)
                CH_OFF: begin
                    if (live) state_d = CH_PRIME;
                end
                CH_PRIME: begin
                    if (!live)         state_d = CH_OFF;
                    else if (sel_rise) state_d = CH_RUN;
                end
                CH_RUN: begin
                    if (!live) state_d = CH_OFF;
                end
                default: state_d = CH_OFF;
            endcase
        end
    end

    // outputs: period counter and generated level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            gck_q <= 1'b0;
        end else if (restart) begin
            cnt_q <= '0;
            gck_q <= 1'b0;
        end else begin
            unique case (state_q)
                CH_PRIME: begin
                    cnt_q <= '0;
                    gck_q <= live && sel_rise;
                end
                CH_RUN: begin
                    if (!live) begin
                        cnt_q <= '0;
                        gck_q <= 1'b0;
                    end else if (cfg.div == '0) begin
                        cnt_q <= '0;
                        gck_q <= sel_lvl;
                    end else if (sel_rise) begin
                        cnt_q <= cnt_n;
                        gck_q <= cnt_n < hi_len;
                    end
                end
                default: begin
                    cnt_q <= '0;
                    gck_q <= 1'b0;
                end
            endcase
        end
    end

    assign gck         = gck_q;
    assign period_done = (state_q == CH_RUN) && live && sel_rise && (cnt_q == cfg.div);

    AST_OFF_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_OFF) |-> !gck_q); // R7
    AST_PRIME_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_PRIME) |-> !gck_q); // R9
    AST_CNT_WITHIN_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= cfg.div); // R4
    AST_RESERVED_SRC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_ok && !restart) |=> !gck_q); // R6
endmodule

// File: rtl/gck_ready_ctl.sv
module gck_ready_ctl
    import gck_pkg::*;
#(
    parameter int NUM_PERIPH = 8,
    localparam int IDX_W = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  commit,
    input  logic [IDX_W-1:0]      commit_idx,
    input  logic [NUM_PERIPH-1:0] live_vec,
    input  logic [NUM_PERIPH-1:0] done_vec,
    output logic                  ready
);
    rdy_state_t       state_q;
    rdy_state_t       state_d;
    logic [IDX_W-1:0] target_q;
    logic             tgt_live;
    logic             tgt_done;

    assign tgt_live = live_vec[target_q];
    assign tgt_done = done_vec[target_q];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= RDY_IDLE;
            target_q <= '0;
        end else begin
            state_q <= state_d;
            if (commit) target_q <= commit_idx;
        end
    end

    always_comb begin
        state_d = state_q;
        if (commit) begin
            state_d = RDY_SETTLE;
        end else begin
            unique case (state_q)
                RDY_IDLE:   state_d = RDY_IDLE;
                RDY_SETTLE: state_d = (tgt_done || !tgt_live) ? RDY_IDLE : RDY_WAIT;
                RDY_WAIT:   state_d = (tgt_done || !tgt_live) ? RDY_IDLE : RDY_WAIT;
                default:    state_d = RDY_IDLE;
            endcase
        end
    end

    always_comb begin
        ready = (state_q == RDY_IDLE);
    end

    AST_READY_DROPS_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !ready); // R8
    AST_WAIT_ONLY_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RDY_SETTLE && !commit && !tgt_live) |=> ready); // R9
endmodule

// File: rtl/gck_gen.sv
module gck_gen
    import gck_pkg::*;
#(
    parameter int NUM_PERIPH = 8,
    parameter int NUM_SRC    = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ctrl_wr,
    input  logic [31:0]           ctrl_wdata,
    output logic [31:0]           ctrl_rdata,
    output logic                  gck_ready,
    input  logic [NUM_SRC-1:0]    src_clk,
    output logic [NUM_PERIPH-1:0] gck_out
);
    localparam int IDX_W = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1;

    logic [NUM_SRC-1:0]        src_lvl;
    logic [NUM_SRC-1:0]        src_rise;
    gck_cfg_t [NUM_PERIPH-1:0] cfg;
    logic                      commit;
    logic [IDX_W-1:0]          commit_idx;
    logic [NUM_PERIPH-1:0]     live_vec;
    logic [NUM_PERIPH-1:0]     done_vec;

    gck_src_edge #(.NUM_SRC(NUM_SRC)) u_src_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_clk  (src_clk),
        .src_lvl  (src_lvl),
        .src_rise (src_rise)
    );

    gck_cfg_regs #(.NUM_PERIPH(NUM_PERIPH)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_wr      (ctrl_wr),
        .ctrl_wdata   (ctrl_wdata),
        .ctrl_rdata   (ctrl_rdata),
        .cfg_o        (cfg),
        .commit_o     (commit),
        .commit_idx_o (commit_idx)
    );

    for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_chan
        logic restart;
        assign restart = commit && (commit_idx == IDX_W'(p));

        gck_channel #(.NUM_SRC(NUM_SRC)) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .cfg         (cfg[p]),
            .restart     (restart),
            .src_lvl     (src_lvl),
            .src_rise    (src_rise),
            .gck         (gck_out[p]),
            .live        (live_vec[p]),
            .period_done (done_vec[p])
        );
    end

    gck_ready_ctl #(.NUM_PERIPH(NUM_PERIPH)) u_ready (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .commit_idx (commit_idx),
        .live_vec   (live_vec),
        .done_vec   (done_vec),
        .ready      (gck_ready)
    );
endmodule

// File: tb/gck_gen_tb.sv
module gck_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 8;
    localparam int NS = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctrl_wr = 1'b0;
    logic [31:0]   ctrl_wdata = '0;
    logic [31:0]   ctrl_rdata;
    logic          gck_ready;
    logic [NS-1:0] src_clk = '0;
    logic [NP-1:0] gck_out;

    typedef struct {
        int    lo;
        int    hi;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   act_q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    int   src_cnt [NS];

    gck_gen #(.NUM_PERIPH(NP), .NUM_SRC(NS)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (ctrl_wdata),
        .ctrl_rdata (ctrl_rdata),
        .gck_ready  (gck_ready),
        .src_clk    (src_clk),
        .gck_out    (gck_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // source s toggles every s+1 cycles: period 2*(s+1)
    initial for (int s = 0; s < NS; s++) src_cnt[s] = 0;
    always @(negedge clk) begin
        for (int s = 0; s < NS; s++) begin
            src_cnt[s] = src_cnt[s] + 1;
            if (src_cnt[s] == s + 1) begin
                src_cnt[s] = 0;
                src_clk[s] <= ~src_clk[s];
            end
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        while (exp_q.size() > 0 && act_q.size() > 0) begin
            exp_t e;
            int   a;
            e = exp_q.pop_front();
            a = act_q.pop_front();
            n_vec++;
            if (a < e.lo || a > e.hi) begin
                n_bad++;
                $display("FAIL %s: actual %0d expected %0d..%0d", e.tag, a, e.lo, e.hi);
            end
        end
    end

    function automatic logic [31:0] mk(input logic cmd, input logic en,
                                       input int div, input int src, input int pid);
        logic [31:0] w;
        w = '0;
        w[31]    = cmd;
        w[28]    = en;
        w[27:20] = div[7:0];
        w[18:16] = src[2:0];
        w[3:0]   = pid[3:0];
        return w;
    endfunction

    task automatic expect_rng(input int lo, input int hi, input string tag);
        exp_t e;
        e.lo = lo;
        e.hi = hi;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic observe(input int v);
        act_q.push_back(v);
    endtask

    task automatic bus_write(input logic [31:0] w);
        @(negedge clk);
        ctrl_wr    = 1'b1;
        ctrl_wdata = w;
        @(negedge clk);
        ctrl_wr    = 1'b0;
    endtask

    task automatic wait_ready(output int lat);
        lat = 0;
        while (!gck_ready && lat < 3000) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic measure(input int ch, output int hi, output int per);
        int guard;
        int lo;
        hi = 0;
        lo = 0;
        guard = 0;
        while (gck_out[ch] && guard < 2000) begin @(negedge clk); guard++; end
        while (!gck_out[ch] && guard < 4000) begin @(negedge clk); guard++; end
        while (gck_out[ch] && guard < 6000) begin @(negedge clk); hi++; guard++; end
        while (!gck_out[ch] && guard < 8000) begin @(negedge clk); lo++; guard++; end
        per = hi + lo;
    endtask

    task automatic high_count(input int ch, input int win, output int cnt);
        cnt = 0;
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            if (gck_out[ch]) cnt++;
        end
    endtask

    task automatic run_live(input int ch, input int src, input int div,
                            input string tag_per, input string tag_hi);
        int p;
        int n;
        int lat;
        int hi;
        int per;
        int hexp;
        p = 2 * (src + 1);
        n = div + 1;
        hexp = (n == 1) ? p / 2 : (n / 2) * p;
        bus_write(mk(1'b1, 1'b1, div, src, ch));
        expect_rng(0, 0, "R8");
        observe(int'(gck_ready));
        wait_ready(lat);
        expect_rng(n * p - 1, (n + 1) * p + 4, "R9");
        observe(lat);
        expect_rng(int'(mk(1'b0, 1'b1, div, src, ch)), int'(mk(1'b0, 1'b1, div, src, ch)), "R2");
        observe(int'(ctrl_rdata));
        measure(ch, hi, per);
        expect_rng(hexp, hexp, tag_hi);
        observe(hi);
        expect_rng(n * p, n * p, tag_per);
        observe(per);
    endtask

    task automatic run_quiet(input int ch, input logic en, input int src, input string tag);
        int lat;
        int cnt;
        bus_write(mk(1'b1, en, 3, src, ch));
        expect_rng(0, 0, "R8");
        observe(int'(gck_ready));
        wait_ready(lat);
        expect_rng(1, 2, "R9");
        observe(lat);
        high_count(ch, 100, cnt);
        expect_rng(0, 0, tag);
        observe(cnt);
    endtask

    initial begin
        int cnt;
        int hi;
        int per;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        expect_rng(1, 1, "R10"); observe(int'(gck_ready));
        expect_rng(0, 0, "R10"); observe(int'(gck_out));
        expect_rng(0, 0, "R10"); observe(int'(ctrl_rdata));

        run_live(2, 1, 2, "R4", "R5");    // N=3, P=4
        run_live(5, 3, 3, "R4", "R5");    // N=4, P=8
        run_live(0, 0, 0, "R4", "R5");    // N=1, P=2
        run_live(7, 5, 4, "R6", "R5");    // N=5, P=12
        run_live(1, 0, 255, "R4", "R5");  // N=256, P=2

        // R1: select-only write with stray fields leaves ch5 settings and waveform
        bus_write(mk(1'b0, 1'b0, 77, 2, 5));
        expect_rng(int'(mk(1'b0, 1'b1, 3, 3, 5)), int'(mk(1'b0, 1'b1, 3, 3, 5)), "R1");
        observe(int'(ctrl_rdata));
        measure(5, hi, per);
        expect_rng(32, 32, "R1");
        observe(per);

        // R3: unsupported slot reads zero, command write ignored
        bus_write(mk(1'b0, 1'b0, 0, 0, 9));
        expect_rng(0, 0, "R3");
        observe(int'(ctrl_rdata));
        bus_write(mk(1'b1, 1'b1, 9, 1, 9));
        expect_rng(1, 1, "R3");
        observe(int'(gck_ready));
        bus_write(mk(1'b0, 1'b0, 0, 0, 2));
        expect_rng(int'(mk(1'b0, 1'b1, 2, 1, 2)), int'(mk(1'b0, 1'b1, 2, 1, 2)), "R3");
        observe(int'(ctrl_rdata));

        // R6: reserved source held low
        run_quiet(3, 1'b1, 6, "R6");
        run_quiet(4, 1'b1, 7, "R6");
        // R7: disabled slot held low
        run_quiet(2, 1'b0, 1, "R7");
        high_count(5, 64, cnt);
        expect_rng(32, 32, "R7");
        observe(cnt);

        repeat (4) @(negedge clk);
        n_bad += exp_q.size() + act_q.size();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule